// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block is a field-configurable, two-level combinational logic array. Twelve dedicated inputs and ten bidirectional pins form twenty-two variables, and each variable is offered to the AND plane in true and complement form. The AND plane builds thirty-two logic product terms and ten direction terms. The OR plane lets any logic term feed any subset of the ten outputs, so one output can OR together as many as all thirty-two terms. A polarity bit on each output selects AND-OR or AND-NOR behaviour. Direction term k enables the driver of pin k. When that driver is off, the pin's outside value goes back into the AND plane.

Configuration is loaded through a synchronous write port with an address and a data word. Pin values are evaluated combinationally from the stored configuration and the current inputs. Each pin is carried on split buses: `pin_in` is the value driven from outside, and `pin_out`/`pin_oe` are the block's own drive. The AND plane sees the resolved pin value: the block's own output where it drives the pin, and `pin_in` where it does not. This feedback settles through a fixed number of unrolled evaluation passes, so no combinational loop exists.

Top module: `pla_array`

## Requirements
- R1: After reset, every AND link is intact (every product term inhibited), every OR link is set and every polarity is active-high. As a result `pin_oe` is all zero and `pin_out` is all zero for any input values.
- R2: Address map for `cfg_addr`. Addresses 0..31 hold the AND row of logic term t. Addresses 32..41 hold the AND row of the direction term of pin k = addr-32. Addresses 64..95 hold the OR row of logic term t = addr-64, where bit k links the term to output k. Address 96 holds the polarity word.
- R3: In an AND row, variable v uses bits [2v+1:2v]. v = 0..11 are `ded_in[v]` and v = 12..21 are pin v-12. Bit 2v is the true link and bit 2v+1 is the complement link. Code 00 is don't care, 01 requires the variable to be 1, 10 requires it to be 0, and 11 forces the term to 0.
- R4: An output is the OR of every active logic term whose OR-row bit for that output is set. One term may feed several outputs at once.
- R5: An output with no active linked logic term yields 0 before polarity.
- R6: A polarity bit of 1 inverts its output, and 0 passes it unchanged.
- R7: `pin_oe[k]` equals the value of direction term k.
- R8: For a pin with `pin_oe` low, the AND plane uses `pin_in`. For a pin with `pin_oe` high, it uses `pin_out` and ignores `pin_in`. Feedback chains through up to PASSES-1 dependent pins settle.
- R9: A configuration write changes the outputs only after the clock edge that captures it.
- R10: Writes to addresses outside the map change no configuration and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset to the unprogrammed state |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 44 | Configuration word |
| ded_in | input | 12 | Dedicated inputs |
| pin_in | input | 10 | Value driven onto each pin from outside |
| pin_out | output | 10 | Value the block drives on each pin |
| pin_oe | output | 10 | Driver enable for each pin |

## Verification
The bench builds the block with its default parameters: 12 inputs, 10 pins, 32 logic terms and 4 feedback passes. With these values the full 44-bit AND row and the real region boundaries at 42, 64 and 96 are exercised. The four passes allow a two-pin feedback chain, pin 3 feeding pin 6 feeding pin 7, to be checked for settling. With `pin_in` held opposite to the driven value, the bench can tell whether the AND plane used the driven value or the outside value.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LK_ANY   = 2'b00,
    LK_TRUE  = 2'b01,
    LK_COMP  = 2'b10,
    LK_BLOCK = 2'b11
  } link_code_e;

  typedef enum logic [1:0] {
    RG_AND,
    RG_OR,
    RG_POL,
    RG_NONE
  } cfg_region_e;

  // One variable's contribution to a product term: bit0 true link, bit1 complement link.
  function automatic logic lit_pass(input logic [1:0] code, input logic x);
    return (~code[0] | x) & (~code[1] | ~x);
  endfunction

  // A link pair with both links intact kills the term whatever the variable.
  function automatic logic pair_blocks(input logic [1:0] code);
    return code == LK_BLOCK;
  endfunction

endpackage

// File: rtl/pla_cfg_regs.sv
module pla_cfg_regs
  import pla_pkg::*;
#(
  parameter int N_IN = 12,
  parameter int N_IO = 10,
  parameter int N_PT = 32,
  localparam int NV       = N_IN + N_IO,
  localparam int N_GATE   = N_PT + N_IO,
  localparam int DW       = 2 * NV,
  localparam int OR_BASE  = 1 << $clog2(N_GATE),
  localparam int POL_ADDR = OR_BASE + (1 << $clog2(N_PT)),
  localparam int AW       = $clog2(POL_ADDR + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                wdata,
  output logic [N_GATE-1:0][DW-1:0]    and_plane,
  output logic [N_PT-1:0][N_IO-1:0]    or_plane,
  output logic [N_IO-1:0]              pol
);

  cfg_region_e      rg;
  logic [AW-1:0]    idx;
  logic [N_GATE-1:0] and_sel;
  logic [N_PT-1:0]   or_sel;
  logic              pol_sel;

  always_comb begin
    rg  = RG_NONE;
    idx = '0;
    if (int'(addr) < N_GATE) begin
      rg  = RG_AND;
      idx = addr;
    end else if (int'(addr) >= OR_BASE && int'(addr) < OR_BASE + N_PT) begin
      rg  = RG_OR;
      idx = addr - AW'(OR_BASE);
    end else if (int'(addr) == POL_ADDR) begin
      rg  = RG_POL;
    end
  end

  assign pol_sel = we && (rg == RG_POL);

  for (genvar g = 0; g < N_GATE; g++) begin : g_and_row
    assign and_sel[g] = we && (rg == RG_AND) && (idx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          and_plane[g] <= '1;
      else if (and_sel[g]) and_plane[g] <= wdata;
    end
    AST_AND_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      and_sel[g] |=> and_plane[g] == $past(wdata)); // R2
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_or_row
    assign or_sel[t] = we && (rg == RG_OR) && (idx == AW'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         or_plane[t] <= '1;
      else if (or_sel[t]) or_plane[t] <= wdata[N_IO-1:0];
    end
    AST_OR_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      or_sel[t] |=> or_plane[t] == $past(wdata[N_IO-1:0])); // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pol <= '0;
    else if (pol_sel) pol <= wdata[N_IO-1:0];
  end

  AST_POL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pol_sel |=> pol == $past(wdata[N_IO-1:0])); // R6

  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rg == RG_NONE) |=> ($stable(and_plane) && $stable(or_plane) && $stable(pol))); // R10

endmodule

// File: rtl/pla_eval.sv
module pla_eval
  import pla_pkg::*;
#(
  parameter int N_IN = 12,
  parameter int N_IO = 10,
  parameter int N_PT = 32,
  localparam int NV     = N_IN + N_IO,
  localparam int N_GATE = N_PT + N_IO,
  localparam int DW     = 2 * NV
) (
  input  logic [N_IN-1:0]              ded_in,
  input  logic [N_IO-1:0]              fb,
  input  logic [N_GATE-1:0][DW-1:0]    and_plane,
  input  logic [N_PT-1:0][N_IO-1:0]    or_plane,
  input  logic [N_IO-1:0]              pol,
  output logic [N_IO-1:0]              pin_val,
  output logic [N_IO-1:0]              pin_en,
  output logic [N_PT-1:0]              logic_hit
);

  logic [NV-1:0]     vars;
  logic [N_GATE-1:0] gate_hit;
  logic [N_IO-1:0]   or_raw;

  assign vars = {fb, ded_in};

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    always_comb begin
      logic h;
      h = 1'b1;
      for (int v = 0; v < NV; v++) h = h & lit_pass(and_plane[g][2*v +: 2], vars[v]);
      gate_hit[g] = h;
    end
  end

  assign logic_hit = gate_hit[N_PT-1:0];
  assign pin_en    = gate_hit[N_GATE-1:N_PT];

  always_comb begin
    for (int k = 0; k < N_IO; k++) begin
      logic acc;
      acc = 1'b0;
      for (int t = 0; t < N_PT; t++) acc = acc | (logic_hit[t] & or_plane[t][k]);
      or_raw[k] = acc;
    end
  end

  assign pin_val = or_raw ^ pol;

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN   = 12,
  parameter int N_IO   = 10,
  parameter int N_PT   = 32,
  parameter int PASSES = 4,
  localparam int NV       = N_IN + N_IO,
  localparam int N_GATE   = N_PT + N_IO,
  localparam int DW       = 2 * NV,
  localparam int OR_BASE  = 1 << $clog2(N_GATE),
  localparam int POL_ADDR = OR_BASE + (1 << $clog2(N_PT)),
  localparam int AW       = $clog2(POL_ADDR + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [N_IN-1:0] ded_in,
  input  logic [N_IO-1:0] pin_in,
  output logic [N_IO-1:0] pin_out,
  output logic [N_IO-1:0] pin_oe
);

  logic [N_GATE-1:0][DW-1:0] and_plane;
  logic [N_PT-1:0][N_IO-1:0] or_plane;
  logic [N_IO-1:0]           pol;

  pla_cfg_regs #(.N_IN(N_IN), .N_IO(N_IO), .N_PT(N_PT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .and_plane(and_plane), .or_plane(or_plane), .pol(pol)
  );

  // Unrolled feedback settling: pass p sees the pins as resolved by pass p-1.
  logic [N_IO-1:0] fb_stage [PASSES+1];
  logic [N_IO-1:0] val_p    [PASSES];
  logic [N_IO-1:0] en_p     [PASSES];
  logic [N_PT-1:0] hit_p    [PASSES];

  assign fb_stage[0] = pin_in;

  for (genvar p = 0; p < PASSES; p++) begin : g_pass
    pla_eval #(.N_IN(N_IN), .N_IO(N_IO), .N_PT(N_PT)) u_eval (
      .ded_in(ded_in), .fb(fb_stage[p]), .and_plane(and_plane), .or_plane(or_plane),
      .pol(pol), .pin_val(val_p[p]), .pin_en(en_p[p]), .logic_hit(hit_p[p])
    );
    assign fb_stage[p+1] = (en_p[p] & val_p[p]) | (~en_p[p] & pin_in);
  end

  assign pin_out = val_p[PASSES-1];
  assign pin_oe  = en_p[PASSES-1];

  // Named observation points for the assertions.
  logic [N_IO-1:0]   fb_used;
  logic [N_PT-1:0]   hit_final;
  logic [N_GATE-1:0] gate_on;
  logic [N_GATE-1:0] gate_blocked;
  logic              settled;

  assign fb_used   = fb_stage[PASSES-1];
  assign hit_final = hit_p[PASSES-1];
  assign gate_on   = {pin_oe, hit_final};
  assign settled   = (fb_stage[PASSES] == fb_stage[PASSES-1]);

  for (genvar g = 0; g < N_GATE; g++) begin : g_blk
    always_comb begin
      logic b;
      b = 1'b0;
      for (int v = 0; v < NV; v++) b = b | pair_blocks(and_plane[g][2*v +: 2]);
      gate_blocked[g] = b;
    end
    AST_BLOCKED_TERM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      gate_blocked[g] |-> !gate_on[g]); // R3
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pin_oe == '0 && pin_out == '0)); // R1

  AST_NO_TERM_GIVES_POL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_final == '0) |-> (pin_out == pol)); // R5

  for (genvar k = 0; k < N_IO; k++) begin : g_pin_chk
    AST_INPUT_PIN_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[k] |-> fb_used[k] == pin_in[k]); // R8
    AST_DRIVEN_PIN_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && pin_oe[k]) |-> fb_used[k] == pin_out[k]); // R8
  end

endmodule

// File: tb/sim_pla_array.sv
module sim_pla_array;

  localparam int NI = 12;
  localparam int NO = 10;
  localparam int AW = 7;
  localparam int DW = 44;
  localparam int DIR_A = 32;
  localparam int OR_A  = 64;
  localparam int POL_A = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] pin_in = '0;
  logic [NO-1:0] pin_out;
  logic [NO-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pla_array u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ded_in(din), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input string what, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lk(input logic [DW-1:0] row, input int v, input logic [1:0] code);
    row[2*v +: 2] = code;
    return row;
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic apply(input logic [NI-1:0] d, input logic [NO-1:0] p);
    @(negedge clk);
    din = d; pin_in = p;
    #1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "oe after reset", pin_oe, '0);
    chk("R1", "out after reset", pin_out, '0);
    apply(12'hFFF, 10'h3FF);
    chk("R1", "oe all ones in", pin_oe, '0);
    chk("R1", "out all ones in", pin_out, '0);
  endtask

  task automatic t_codes();
    logic [DW-1:0] r0;
    r0 = lk(lk('0, 0, 2'b01), 1, 2'b10);
    wr(0, r0);
    wr(OR_A + 0, 44'h001);
    // R9: write of direction row 0 is not visible before its clock edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(DIR_A); cfg_wdata = '0;
    #1;
    chk("R9", "oe before edge", pin_oe, '0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R7", "oe after edge", pin_oe, 10'h001);
    for (int c = 0; c < 4; c++) begin
      apply(NI'(c), '0);
      chk("R3", "true/comp term", 10'(pin_out[0]), 10'(c == 1));
    end
    apply(12'h021, '0);
    chk("R3", "dont care var5", 10'(pin_out[0]), 10'd1);
    wr(0, lk(r0, 2, 2'b11));
    chk("R3", "both links inhibit", 10'(pin_out[0]), 10'd0);
    wr(0, r0);
    chk("R3", "restored term", 10'(pin_out[0]), 10'd1);
  endtask

  task automatic t_share();
    wr(1, lk('0, 2, 2'b01));
    wr(OR_A + 1, 44'h009);   // R2: OR row of term 1 -> outputs 0 and 3
    wr(DIR_A + 3, '0);
    chk("R7", "oe pins 0 and 3", pin_oe, 10'h009);
    for (int c = 0; c < 8; c++) begin
      apply(NI'(c), '0);
      chk("R4", "shared out3", 10'(pin_out[3]), 10'(c[2]));
      chk("R4", "shared out0", 10'(pin_out[0]), 10'((c[0] & ~c[1]) | c[2]));
    end
  endtask

  task automatic t_polarity();
    wr(DIR_A + 5, '0);
    apply(12'h001, '0);
    chk("R5", "empty or", 10'(pin_out[5]), 10'd0);
    wr(POL_A, 44'h021);
    chk("R6", "empty or inverted", 10'(pin_out[5]), 10'd1);
    chk("R6", "term inverted", 10'(pin_out[0]), 10'd0);
    apply(12'h002, '0);
    chk("R6", "and-nor high", 10'(pin_out[0]), 10'd1);
    wr(POL_A, '0);
    chk("R6", "polarity restored", 10'(pin_out[0]), 10'd0);
  endtask

  task automatic t_feedback();
    wr(2, lk('0, NI + 3, 2'b01));
    wr(OR_A + 2, 44'h040);
    wr(DIR_A + 6, '0);
    wr(3, lk('0, NI + 6, 2'b01));
    wr(OR_A + 3, 44'h080);
    wr(DIR_A + 7, '0);
    apply(12'h004, 10'h000);
    chk("R8", "driven pin3 feeds pin6", 10'(pin_out[6]), 10'd1);
    chk("R8", "chain pin6 feeds pin7", 10'(pin_out[7]), 10'd1);
    apply(12'h000, 10'h008);
    chk("R8", "pin_in ignored when driven", 10'(pin_out[6]), 10'd0);
    wr(DIR_A + 3, lk('0, 0, 2'b11));
    chk("R7", "pin3 released", 10'(pin_oe[3]), 10'd0);
    chk("R8", "released pin3 from pin_in hi", {pin_out[7], pin_out[6]}, 10'd3);
    apply(12'h004, 10'h000);
    chk("R8", "released pin3 from pin_in lo", {pin_out[7], pin_out[6]}, 10'd0);
  endtask

  task automatic t_unmapped();
    logic [NO-1:0] so, se;
    apply(12'h005, 10'h008);
    so = pin_out; se = pin_oe;
    wr(42, '0);
    wr(50, '0);
    wr(63, '0);
    wr(98, '1);
    wr(127, '1);
    chk("R10", "out after stray writes", pin_out, so);
    chk("R10", "oe after stray writes", pin_oe, se);
  endtask

  initial begin
    t_reset();
    t_codes();
    t_share();
    t_polarity();
    t_feedback();
    t_unmapped();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule